// File: doc/BRIEF.md
# Mirrored Shared Word Memory for Two Buses

This block puts one single-port word array behind two processor buses. The X bus reaches the array through one 16K-word window at the top of its 64K address map, 0xC000 to 0xFFFF. The Y bus reaches the same array through two windows, 0x8000 to 0xBFFF and 0xC000 to 0xFFFF. Both Y windows fold onto the same words, so a Y write through either window changes the word that every other window reads.

Each bus raises `*_req` with an address, a write flag and write data, and holds them until its `*_ready` pulses. Every access costs one wait state. The array has one port, so a multiplexer in front of it takes one access per cycle. When both buses ask in the same cycle, X goes first and Y follows one cycle later, and the pair finishes in two cycles. A request outside the windows its bus decodes gets no reply and never delays the other bus.

The array holds 2^AW words (AW at most 14). With AW = 14 each window maps one-to-one onto the storage. With a smaller AW the storage repeats inside every window. The default AW = 12 keeps the elaborated array small.

Top module: `smem_mirror_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `x_ready` and `y_ready` are low.
- R2: X decodes only addresses whose top two bits are 11 (0xC000 to 0xFFFF). Any other X request never gets `x_ready`, never changes storage and never delays a Y access.
- R3: Y decodes only addresses with bit 15 set (0x8000 to 0xFFFF). A Y request below 0x8000 never gets `y_ready`, never changes storage and never delays an X access.
- R4: The word index is address bits [AW-1:0] on both buses and in every window. A Y write at 0x8000+n is read back at 0xC000+n from both buses. At the default AW = 12 the index also repeats every 0x1000 inside a window.
- R5: A lone decoded request that is first presented in cycle t gets its ready in cycle t+1. That is one wait state. The ready lasts one cycle for each access.
- R6: When both buses present decoded requests in the same cycle t, `x_ready` rises in t+1 and `y_ready` in t+2. If both write the same word, the value Y wrote is the one that stays.
- R7: In a read's ready cycle, `*_rdata` equals the value most recently written to that word index by either bus.
- R8: `x_ready` and `y_ready` are never high in the same cycle.
- R9: A bus's ready is high only if that bus held its request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_req | input | 1 | X access request, held until `x_ready` |
| x_we | input | 1 | X write (1) or read (0) |
| x_addr | input | 16 | X byte-free word address |
| x_wdata | input | DW | X write data |
| x_rdata | output | DW | X read data, valid with `x_ready` |
| x_ready | output | 1 | X access completes this cycle |
| y_req | input | 1 | Y access request, held until `y_ready` |
| y_we | input | 1 | Y write (1) or read (0) |
| y_addr | input | 16 | Y word address |
| y_wdata | input | DW | Y write data |
| y_rdata | output | DW | Y read data, valid with `y_ready` |
| y_ready | output | 1 | Y access completes this cycle |

## Verification
A wrong alias fold or a wrong window decode shows up at the first read through the other window or the other bus: the data is wrong, or a ready is missing or spurious in the cycle right after the request. A fault in the grant state shows up within one or two cycles of a collision. It appears as both readies high together, as Y finishing before X, as a ready repeating for one held request, or as a miss on one bus stalling the other. A wrong write order on a shared word stays hidden until that word is read again, so the bench reads back every word it writes.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int BUS_AW = 16;

  // X bus: single window 0xC000..0xFFFF
  function automatic logic x_window(input logic [BUS_AW-1:0] a);
    return a[BUS_AW-1:BUS_AW-2] == 2'b11;
  endfunction

  // Y bus: two aliased windows 0x8000..0xBFFF and 0xC000..0xFFFF
  function automatic logic y_window(input logic [BUS_AW-1:0] a);
    return a[BUS_AW-1];
  endfunction

  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_X = 2'd1, SRC_Y = 2'd2} src_e;
endpackage

// File: rtl/smem_decode.sv
module smem_decode
  import smem_pkg::*;
#(
  parameter int AW   = 12,
  parameter bit IS_Y = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output logic [AW-1:0]     idx
);
  logic in_window;

  generate
    if (IS_Y) begin : g_ydec
      assign in_window = y_window(addr);
    end else begin : g_xdec
      assign in_window = x_window(addr);
    end
  endgenerate

  assign hit = req & in_window;
  assign idx = addr[AW-1:0];

  // every decoded access lies in the upper half of the map
  p_hit_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> addr >= 16'h8000);

  generate
    if (!IS_Y) begin : g_xchk
      p_x_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> addr >= 16'hC000);
    end
  endgenerate
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter
  import smem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic x_req,
  input  logic x_hit,
  input  logic y_req,
  input  logic y_hit,
  output logic x_issue,
  output logic y_issue,
  output src_e src,
  output logic x_ready,
  output logic y_ready
);
  logic x_elig, y_elig;

  // a bus whose access is finishing this cycle still holds req: do not re-issue it
  assign x_elig  = x_hit & ~x_ready;
  assign y_elig  = y_hit & ~y_ready;
  assign x_issue = x_elig;
  assign y_issue = y_elig & ~x_elig;

  always_comb begin
    if (x_issue)      src = SRC_X;
    else if (y_issue) src = SRC_Y;
    else              src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_ready <= 1'b0;
      y_ready <= 1'b0;
    end else begin
      x_ready <= x_issue;
      y_ready <= y_issue;
    end
  end

  p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_ready && y_ready));

  p_x_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x_issue |=> x_ready);

  p_y_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    y_issue |=> y_ready);

  p_x_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x_ready |=> !x_ready);

  p_y_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    y_ready |=> !y_ready);

  p_x_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && x_hit && y_req && y_hit && !x_ready && !y_ready) |-> (x_issue && !y_issue));

  p_y_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (x_issue && y_hit && !y_ready) |=> (y_issue || !y_hit));

  p_x_asked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    x_ready |-> $past(x_req));

  p_y_asked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    y_ready |-> $past(y_req));
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      rd_q <= mem[idx];
    end
  end

  assign rdata = rd_q;

  // a read right after a write to the same word returns the written value
  p_write_then_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we && $past(en && we) && idx == $past(idx)) |=> (rdata == $past(wdata, 2)));
endmodule

// File: rtl/smem_mirror_top.sv
module smem_mirror_top
  import smem_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_req,
  input  logic              x_we,
  input  logic [BUS_AW-1:0] x_addr,
  input  logic [DW-1:0]     x_wdata,
  output logic [DW-1:0]     x_rdata,
  output logic              x_ready,
  input  logic              y_req,
  input  logic              y_we,
  input  logic [BUS_AW-1:0] y_addr,
  input  logic [DW-1:0]     y_wdata,
  output logic [DW-1:0]     y_rdata,
  output logic              y_ready
);
  logic          x_hit, y_hit, x_issue, y_issue;
  logic [AW-1:0] x_idx, y_idx;
  src_e          src;

  logic          mem_en, mem_we;
  logic [AW-1:0] mem_idx;
  logic [DW-1:0] mem_wdata, mem_rdata;

  initial p_aw_fits_r4: assert (AW >= 1 && AW <= 14);

  smem_decode #(.AW(AW), .IS_Y(1'b0)) u_xdec (
    .clk(clk), .rst_n(rst_n), .req(x_req), .addr(x_addr), .hit(x_hit), .idx(x_idx)
  );

  smem_decode #(.AW(AW), .IS_Y(1'b1)) u_ydec (
    .clk(clk), .rst_n(rst_n), .req(y_req), .addr(y_addr), .hit(y_hit), .idx(y_idx)
  );

  smem_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .x_req(x_req), .x_hit(x_hit), .y_req(y_req), .y_hit(y_hit),
    .x_issue(x_issue), .y_issue(y_issue), .src(src),
    .x_ready(x_ready), .y_ready(y_ready)
  );

  // request multiplexer in front of the single port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_idx   = '0;
    mem_wdata = '0;
    unique case (src)
      SRC_X: begin
        mem_en = 1'b1; mem_we = x_we; mem_idx = x_idx; mem_wdata = x_wdata;
      end
      SRC_Y: begin
        mem_en = 1'b1; mem_we = y_we; mem_idx = y_idx; mem_wdata = y_wdata;
      end
      default: ;
    endcase
  end

  smem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we),
    .idx(mem_idx), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  assign x_rdata = mem_rdata;
  assign y_rdata = mem_rdata;

  // a miss on X must not hold off a decoded Y request
  p_x_miss_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && !x_hit && y_hit && !y_ready) |-> y_issue);

  p_y_miss_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (y_req && !y_hit && x_hit && !x_ready) |-> x_issue);
endmodule

// File: tb/sim_smem_mirror_top.sv
module sim_smem_mirror_top;
  localparam int WORDS = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_req = 0, x_we = 0, y_req = 0, y_we = 0;
  logic [15:0] x_addr = 0, y_addr = 0, x_wdata = 0, y_wdata = 0;
  logic [15:0] x_rdata, y_rdata;
  logic x_ready, y_ready;

  int compared = 0;
  int mismatched = 0;
  int mdl [int];
  logic xq_prev = 0, yq_prev = 0;
  bit run_mon = 0;

  always #5 clk = ~clk;

  smem_mirror_top u0 (
    .clk(clk), .rst_n(rst_n),
    .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
    .x_rdata(x_rdata), .x_ready(x_ready),
    .y_req(y_req), .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
    .y_rdata(y_rdata), .y_ready(y_ready)
  );

  function automatic int word_of(input logic [15:0] a);
    return int'(a) % WORDS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every-clock comparison of handshake rules
  always @(posedge clk) begin
    xq_prev <= x_req;
    yq_prev <= y_req;
  end

  always @(negedge clk) begin
    if (run_mon) begin
      check(!(x_ready && y_ready), "R8", {x_ready, y_ready}, 0);
      check(!x_ready || xq_prev, "R9 x", x_ready, 0);
      check(!y_ready || yq_prev, "R9 y", y_ready, 0);
    end
  end

  // xl / yl: expected ready cycle after presentation, 0 = never, -1 = bus idle
  task automatic access(input bit xwe, input logic [15:0] xa, input logic [15:0] xd, input int xl,
                        input bit ywe, input logic [15:0] ya, input logic [15:0] yd, input int yl,
                        input string tag);
    int xgot = 0, ygot = 0;
    x_req = (xl >= 0); x_we = xwe; x_addr = xa; x_wdata = xd;
    y_req = (yl >= 0); y_we = ywe; y_addr = ya; y_wdata = yd;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      if (x_ready) begin
        if (xgot != 0) check(0, {tag, " R5 x repeat"}, c, 0);
        else begin
          xgot = c;
          if (xwe) mdl[word_of(xa)] = int'(xd);
          else check(x_rdata == 16'(mdl[word_of(xa)]), {tag, " R7 x data"},
                     x_rdata, mdl[word_of(xa)]);
          x_req = 0;
        end
      end
      if (y_ready) begin
        if (ygot != 0) check(0, {tag, " R5 y repeat"}, c, 0);
        else begin
          ygot = c;
          if (ywe) mdl[word_of(ya)] = int'(yd);
          else check(y_rdata == 16'(mdl[word_of(ya)]), {tag, " R7 y data"},
                     y_rdata, mdl[word_of(ya)]);
          y_req = 0;
        end
      end
    end
    x_req = 0; y_req = 0;
    if (xl >= 0) check(xgot == xl, {tag, " x latency"}, xgot, xl);
    if (yl >= 0) check(ygot == yl, {tag, " y latency"}, ygot, yl);
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!x_ready && !y_ready, "R1 in reset", {x_ready, y_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!x_ready && !y_ready, "R1 after reset", {x_ready, y_ready}, 0);
    run_mon = 1;

    // R5 lone accesses, R7 readback
    access(1, 16'hC010, 16'h1111, 1,  0, 0, 0, -1, "R5 x write");
    access(0, 16'hC010, 0, 1,         0, 0, 0, -1, "R7 x read");
    access(0, 0, 0, -1,  1, 16'h8020, 16'hA5A5, 1, "R5 y write");
    // R4 alias: Y low window seen at 0xC000+n from both buses
    access(0, 16'hC020, 0, 1,  0, 0, 0, -1, "R4 x alias read");
    access(0, 0, 0, -1,  0, 16'hC020, 0, 1, "R4 y alias read");
    access(0, 0, 0, -1,  1, 16'hC030, 16'h5A5A, 1, "R4 y high write");
    access(0, 0, 0, -1,  0, 16'h8030, 0, 1, "R4 y low read");
    // R4 repeat every 0x1000 at default AW
    access(0, 0, 0, -1,  1, 16'h9000, 16'h0F0F, 1, "R4 repeat write");
    access(0, 16'hC000, 0, 1,  0, 0, 0, -1, "R4 repeat read");

    // R2: X below 0xC000 ignored, storage unchanged
    access(1, 16'h8000, 16'hDEAD, 0,  0, 0, 0, -1, "R2 x miss");
    access(1, 16'h4000, 16'hDEAD, 0,  0, 0, 0, -1, "R2 x miss low");
    access(0, 0, 0, -1,  0, 16'h8000, 0, 1, "R2 word intact");
    // R3: Y below 0x8000 ignored
    access(0, 0, 0, -1,  1, 16'hC234, 16'h7777, 1, "R3 seed");
    access(0, 0, 0, -1,  1, 16'h1234, 16'hBEEF, 0, "R3 y miss");
    access(0, 0, 0, -1,  0, 16'h8234, 0, 1, "R3 word intact");

    // R6 collisions
    access(1, 16'hC100, 16'h2222, 1,  0, 16'h8020, 0, 2, "R6 xw yr");
    access(0, 16'hC100, 0, 1,  1, 16'hC101, 16'h3333, 2, "R6 xr yw");
    access(1, 16'hC040, 16'h4444, 1,  1, 16'h8040, 16'h6666, 2, "R6 same word");
    access(0, 16'hC040, 0, 1,  0, 0, 0, -1, "R6 y wins");
    // a miss on one bus does not stall the other
    access(1, 16'h8050, 16'hBAD0, 0,  1, 16'h8050, 16'h1357, 1, "R2 x miss y hit");
    access(0, 16'hC050, 0, 1,  0, 16'h7050, 0, 0, "R3 y miss x hit");

    run_mon = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule